// File: doc/BRIEF.md
# Register Strobe and Bus Source Control

This block turns the decoded operation lines and the timing slot of a small accumulator machine into the control strobes for its data register and memory. It also drives the select code of the shared 16-bit bus and holds the interrupt-enable flag. The opcode decoder, the sequence counter, the register file and the memory sit outside the block. Their one-hot outputs and status bits arrive here as plain inputs.

The strobes and the bus select code are combinational in the current inputs. The only state is the interrupt-enable flag. It behaves as a JK flip-flop. Its set term is an I/O-class instruction in slot T3 with IR bit 7 high. Its clear terms are the same condition with IR bit 6 high, or the interrupt cycle in slot T2.

The program-counter source request is formed inside the block. The other six bus source requests come in on `src_req`. At most one request may be active per cycle.

Top module: `reg_ctrl`

## Requirements
- R1: `dr_load` is high in the same cycle exactly when slot T4 is active (`t_slot[4]`) and any of operation lines 0, 1, 2 or 6 is high.
- R2: `dr_incr` is high exactly when operation line 6 and slot T5 are both active.
- R3: `mem_write` is high exactly when one of these holds: `int_cycle` with T1, line 3 with T4, line 5 with T4, or line 6 with T6.
- R4: `bus_sel` encodes the single active source request. `src_req[k]` selects code k+1: AR=1, PC=2, DR=3, AC=4, IR=5, TR=6, memory=7. With no request the code is 0.
- R5: The PC source (code 2) is requested internally when `int_cycle` coincides with T0, or when operation line 5 coincides with T4. `src_req[1]` also requests PC.
- R6: `ien` goes to 1 at the next rising edge when line 7, `ind_bit`, T3 and `ir7` are all high and the clear terms are low. Without `ind_bit` this condition has no effect.
- R7: `ien` goes to 0 at the next edge when line 7, `ind_bit`, T3 and `ir6` are all high and `ir7` is low.
- R8: `ien` goes to 0 at the next edge when `int_cycle` and T2 are both high.
- R9: When the set and clear terms are both active in one cycle, `ien` inverts at the next edge.
- R10: A synchronous active-high `rst` forces `ien` to 0. With no set or clear term, `ien` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_op | input | 8 | One-hot decoded operation lines 0..7 |
| t_slot | input | 7 | One-hot timing slots T0..T6 |
| ind_bit | input | 1 | Indirect/class bit of the instruction |
| int_cycle | input | 1 | Interrupt-cycle flag |
| ir6 | input | 1 | Instruction register bit 6 |
| ir7 | input | 1 | Instruction register bit 7 |
| src_req | input | 7 | External bus source requests, bit k selects code k+1 |
| dr_load | output | 1 | Data register load strobe |
| dr_incr | output | 1 | Data register increment strobe |
| mem_write | output | 1 | Memory write strobe |
| bus_sel | output | 3 | Bus source select code |
| ien | output | 1 | Interrupt-enable flag |

## Verification
The assertions run on every clock. They check the next-state behaviour of the interrupt-enable flag for set, clear, toggle and hold. They check that the load strobe only appears in T4 and that an interrupt cycle in T0 puts the PC on the bus. They also flag any cycle with more than one bus source request.

The exact strobe equations, the full code for each source, the reset value, and the cases where the I/O condition lacks the indirect bit can only be shown by the bench. It does this through its table of slot, operation and request combinations and its directed flag sequences.

// File: rtl/reg_ctrl.sv
module reg_ctrl #(
  parameter int NSRC = 7,
  localparam int SW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      dec_op,
  input  logic [6:0]      t_slot,
  input  logic            ind_bit,
  input  logic            int_cycle,
  input  logic            ir6,
  input  logic            ir7,
  input  logic [NSRC-1:0] src_req,
  output logic            dr_load,
  output logic            dr_incr,
  output logic            mem_write,
  output logic [SW-1:0]   bus_sel,
  output logic            ien
);

  logic            io_slot;
  logic            j_in, k_in;
  logic [NSRC-1:0] req;

  assign dr_load   = (dec_op[0] | dec_op[1] | dec_op[2] | dec_op[6]) & t_slot[4];
  assign dr_incr   = dec_op[6] & t_slot[5];
  assign mem_write = (int_cycle & t_slot[1]) | ((dec_op[3] | dec_op[5]) & t_slot[4])
                   | (dec_op[6] & t_slot[6]);

  always_comb begin
    req    = src_req;
    req[1] = src_req[1] | (int_cycle & t_slot[0]) | (dec_op[5] & t_slot[4]);
  end

  always_comb begin
    bus_sel = '0;
    for (int k = 0; k < NSRC; k++)
      for (int b = 0; b < SW; b++)
        if (req[k] && (((k + 1) >> b) & 1) == 1)
          bus_sel[b] = 1'b1;
  end

  assign io_slot = dec_op[7] & ind_bit & t_slot[3];
  assign j_in    = io_slot & ir7;
  assign k_in    = (io_slot & ir6) | (int_cycle & t_slot[2]);

  always_ff @(posedge clk) begin
    if (rst)                ien <= 1'b0;
    else if (j_in && k_in)  ien <= ~ien;
    else if (j_in)          ien <= 1'b1;
    else if (k_in)          ien <= 1'b0;
  end

  // R4: only one source may drive the bus per cycle
  a_r4_single_source: assert property (@(posedge clk) disable iff (rst) $onehot0(req));
  a_r1_load_in_t4: assert property (@(posedge clk) disable iff (rst) dr_load |-> t_slot[4]);
  a_r5_int_pc: assert property (@(posedge clk) disable iff (rst)
    (int_cycle && t_slot[0]) |-> bus_sel == SW'(2));
  a_r6_set: assert property (@(posedge clk) disable iff (rst) (j_in && !k_in) |=> ien);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst) (k_in && !j_in) |=> !ien);
  a_r9_toggle: assert property (@(posedge clk) disable iff (rst)
    (j_in && k_in) |=> ien != $past(ien));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!j_in && !k_in) |=> $stable(ien));

endmodule

// File: tb/reg_ctrl_test.sv
module reg_ctrl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] dec_op;
  logic [6:0] t_slot;
  logic       ind_bit, int_cycle, ir6, ir7;
  logic [6:0] src_req;
  logic       dr_load, dr_incr, mem_write, ien;
  logic [2:0] bus_sel;
  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  reg_ctrl uut (
    .clk(clk), .rst(rst), .dec_op(dec_op), .t_slot(t_slot), .ind_bit(ind_bit),
    .int_cycle(int_cycle), .ir6(ir6), .ir7(ir7), .src_req(src_req),
    .dr_load(dr_load), .dr_incr(dr_incr), .mem_write(mem_write),
    .bus_sel(bus_sel), .ien(ien)
  );

  // {dec_op, t_slot, int_cycle, src_req, dr_load, dr_incr, mem_write, bus_sel}
  localparam int NV = 15;
  localparam logic [28:0] VEC [NV] = '{
    {8'h01, 7'h10, 1'b0, 7'h00, 1'b1, 1'b0, 1'b0, 3'd0},
    {8'h02, 7'h10, 1'b0, 7'h04, 1'b1, 1'b0, 1'b0, 3'd3},
    {8'h04, 7'h10, 1'b0, 7'h01, 1'b1, 1'b0, 1'b0, 3'd1},
    {8'h40, 7'h10, 1'b0, 7'h00, 1'b1, 1'b0, 1'b0, 3'd0},
    {8'h40, 7'h20, 1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 3'd0},
    {8'h40, 7'h40, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 3'd0},
    {8'h08, 7'h10, 1'b0, 7'h08, 1'b0, 1'b0, 1'b1, 3'd4},
    {8'h20, 7'h10, 1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 3'd2},
    {8'h00, 7'h02, 1'b1, 7'h00, 1'b0, 1'b0, 1'b1, 3'd0},
    {8'h00, 7'h01, 1'b1, 7'h00, 1'b0, 1'b0, 1'b0, 3'd2},
    {8'h08, 7'h08, 1'b0, 7'h40, 1'b0, 1'b0, 1'b0, 3'd7},
    {8'h10, 7'h10, 1'b0, 7'h20, 1'b0, 1'b0, 1'b0, 3'd6},
    {8'h80, 7'h10, 1'b0, 7'h10, 1'b0, 1'b0, 1'b0, 3'd5},
    {8'h01, 7'h20, 1'b0, 7'h02, 1'b0, 1'b0, 1'b0, 3'd2},
    {8'h01, 7'h02, 1'b0, 7'h00, 1'b0, 1'b0, 1'b0, 3'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dec_op = '0; t_slot = '0; ind_bit = 0; int_cycle = 0; ir6 = 0; ir7 = 0; src_req = '0;
  endtask

  task automatic pulse(input logic [7:0] d, input logic [6:0] t, input logic i,
                       input logic r, input logic b6, input logic b7);
    @(negedge clk);
    dec_op = d; t_slot = t; ind_bit = i; int_cycle = r; ir6 = b6; ir7 = b7;
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R10 reset", ien, 0);

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      {dec_op, t_slot, int_cycle, src_req} = VEC[n][28:6];
      #2;
      check("R1 dr_load", dr_load, VEC[n][5]);
      check("R2 dr_incr", dr_incr, VEC[n][4]);
      check("R3 mem_write", mem_write, VEC[n][3]);
      check("R4/R5 bus_sel", bus_sel, VEC[n][2:0]);
    end
    idle();

    pulse(8'h80, 7'h08, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 no set without ind_bit", ien, 0);
    pulse(8'h80, 7'h08, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R6 set", ien, 1);
    pulse(8'h00, 7'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 hold", ien, 1);
    pulse(8'h80, 7'h08, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 clear", ien, 0);
    pulse(8'h80, 7'h08, 1'b1, 1'b0, 1'b0, 1'b1);
    pulse(8'h00, 7'h04, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 clear by interrupt T2", ien, 0);
    pulse(8'h80, 7'h08, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R9 toggle 0->1", ien, 1);
    pulse(8'h80, 7'h08, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R9 toggle 1->0", ien, 0);
    pulse(8'h80, 7'h08, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R10 reset clears set flag", ien, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule